// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the transmit-error and receive-error counts of a CAN node and decides from them which fault state the node is in: error-active, error-passive or bus-off. The protocol engine reports what happened on the bus through single-cycle event strobes. These cover errors seen while receiving, error flags sent while transmitting, bit errors inside error or overload flags, long runs of dominant bits, and good transmissions and receptions. The block adds up the effects of all strobes raised in one clock cycle and applies them together. The counter values and the state are visible on outputs one clock after the triggering edge. A separate output tells the engine whether an error must be signalled with an active or a passive flag.

Once the transmit count reaches the bus-off limit, the node stops reacting to traffic events. The receive counter is cleared and then counts idle sequences of eleven consecutive recessive bits, sampled through a bit-valid strobe. After 128 such sequences both counters clear, the node is error-active again, and a one-cycle recovery interrupt fires. Software may load both counters with one value at any time outside bus-off. A synchronous module clear returns everything to the reset condition.

Top module: `can_fault_conf`

## Requirements
- R1: Asynchronous reset (rst_n low) or a synchronous mod_clr pulse sets both counters to 0, leaves bus-off and shows state 0. mod_clr overrides every other input, including during bus-off.
- R2: fc_state encodes 0 = error-active (both counts below 128), 1 = error-passive (either count 128 or more, not bus-off), 2 = bus-off. flag_passive is 1 exactly when fc_state is 1.
- R3: ev_rx_err adds 1 and ev_rx_flagerr adds 8 to the receive count. Receive increments apply only when the receive count before the edge is below 128; from 128 upward it does not rise.
- R4: ev_tx_flag and ev_tx_flagerr each add 8 to the transmit count. ev_dom_run adds 8 to both counts, with the receive part subject to R3.
- R5: ev_tx_ok subtracts 1 from the transmit count, and a count of 0 stays 0.
- R6: ev_rx_ok leaves a receive count of 0 at 0, subtracts 1 from counts 1 to 127, and loads 119 into counts of 128 or more.
- R7: All strobes raised in the same cycle combine. The decrement or reload of R5 and R6 is taken from the old count, and the increments are added on top.
- R8: When the resulting transmit count would be 256 or more, the node enters bus-off (state 2). The transmit count shows 256, the receive count becomes 0, and all event strobes and software writes are ignored until recovery or mod_clr.
- R9: In bus-off, each run of 11 consecutive cycles with bit_valid high and bus_bit high (recessive) adds 1 to the receive count. A valid dominant bit (bus_bit low) restarts the run. Cycles with bit_valid low neither advance nor restart it.
- R10: The run that would take the receive count to 128 instead clears both counts and returns the state to 0. recov_irq is 1 for exactly the next cycle.
- R11: Outside bus-off, sw_wr loads sw_wdata into both counts and takes priority over any event strobes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_clr | input | 1 | Synchronous module clear |
| ev_rx_err | input | 1 | Receiver detected an error (+1 receive) |
| ev_rx_flagerr | input | 1 | Receiver +8 event (bit error inside own flag, or dominant after flag) |
| ev_tx_flag | input | 1 | Transmitter sent an error flag (+8 transmit) |
| ev_tx_flagerr | input | 1 | Transmitter bit error inside own active or overload flag (+8 transmit) |
| ev_dom_run | input | 1 | Dominant-run limit reached after a flag (+8 both) |
| ev_tx_ok | input | 1 | Frame transmitted successfully |
| ev_rx_ok | input | 1 | Frame received successfully |
| bit_valid | input | 1 | Sample strobe for bus_bit |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| sw_wr | input | 1 | Software load of both counters |
| sw_wdata | input | 8 | Value loaded by sw_wr |
| tec | output | 9 | Transmit-error count |
| rec | output | 8 | Receive-error count (idle-run count in bus-off) |
| fc_state | output | 2 | Fault state, encoding in R2 |
| flag_passive | output | 1 | Error flag type select, 1 = passive flag |
| recov_irq | output | 1 | One-cycle bus-off recovery interrupt |

## Verification
Both counters drive the ports directly, so a wrong count or a wrong combination rule shows up on tec, rec or fc_state one cycle after the edge that caused it. The only hidden state is the recessive-run counter and the bus-off flag. A run counter that slips shows only as a receive increment arriving a bit early or late, so recovery is driven with runs broken by dominant bits and by gaps in bit_valid, and rec is compared after every bit. A bus-off flag that is set or cleared wrongly shows at once, because fc_state and the transmit count of 256 change with it.

// File: rtl/canfc_pkg.sv
`timescale 1ns/1ps
package canfc_pkg;
   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'd0,
      FC_PASSIVE = 2'd1,
      FC_BUSOFF  = 2'd2
   } fc_state_e;
endpackage

// File: rtl/canfc_run_detect.sv
`timescale 1ns/1ps
// Counts consecutive recessive samples; pulses run_done on the last one.
module canfc_run_detect #(
   parameter int unsigned RUN_LEN = 11,
   parameter bit          REC_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bit_valid,
   input  logic bus_bit,
   output logic run_done
);
   localparam int unsigned RW = $clog2(RUN_LEN + 1);

   logic          is_rec;
   logic [RW-1:0] run_q;

   generate
      if (REC_LVL) begin : g_rec_high
         assign is_rec = bus_bit;
      end else begin : g_rec_low
         assign is_rec = ~bus_bit;
      end
   endgenerate

   assign run_done = bit_valid && is_rec && (run_q == RW'(RUN_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (clr) begin
         run_q <= '0;
      end else if (bit_valid) begin
         if (!is_rec || run_done) run_q <= '0;
         else                     run_q <= run_q + 1'b1;
      end
   end
endmodule

// File: rtl/canfc_tx_count.sv
`timescale 1ns/1ps
// Transmit-error counter with saturating decrement and bus-off detection.
module canfc_tx_count #(
   parameter int unsigned W       = 9,
   parameter int unsigned OFF_LIM = 256
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         hold,
   input  logic         recover,
   input  logic         sw_ld,
   input  logic [W-1:0] sw_val,
   input  logic [1:0]   inc8_n,
   input  logic         dec_req,
   output logic [W-1:0] cnt,
   output logic         off_hit
);
   localparam int unsigned SW = W + 1;

   logic          dec;
   logic [SW-1:0] sum_w;

   always_comb begin
      dec     = dec_req && (cnt != '0);
      sum_w   = {1'b0, cnt} - {{W{1'b0}}, dec} + {{(SW-5){1'b0}}, inc8_n, 3'b000};
      off_hit = !hold && !sw_ld && (sum_w >= SW'(OFF_LIM));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr || recover) begin
         cnt <= '0;
      end else if (!hold) begin
         if (sw_ld)        cnt <= sw_val;
         else if (off_hit) cnt <= W'(OFF_LIM);
         else              cnt <= sum_w[W-1:0];
      end
   end
endmodule

// File: rtl/canfc_rx_count.sv
`timescale 1ns/1ps
// Receive-error counter; counts idle runs while the node is bus-off.
module canfc_rx_count #(
   parameter int unsigned W          = 8,
   parameter int unsigned PASS_LIM   = 128,
   parameter int unsigned RELOAD     = 119,
   parameter int unsigned RECOV_RUNS = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         busoff,
   input  logic         enter_off,
   input  logic         sw_ld,
   input  logic [W-1:0] sw_val,
   input  logic         inc1,
   input  logic [1:0]   inc8_n,
   input  logic         good_rx,
   input  logic         run_done,
   output logic [W-1:0] cnt,
   output logic         recov_hit
);
   logic [W-1:0] base_w;
   logic [W-1:0] inc_w;
   logic [W-1:0] next_w;
   logic         below;

   always_comb begin
      below  = (cnt < W'(PASS_LIM));
      base_w = cnt;
      if (good_rx) begin
         if (cnt == '0) base_w = '0;
         else if (below) base_w = cnt - 1'b1;
         else base_w = W'(RELOAD);
      end
      inc_w     = {{(W-5){1'b0}}, inc8_n, 3'b000} + {{(W-1){1'b0}}, inc1};
      next_w    = below ? (base_w + inc_w) : base_w;
      recov_hit = busoff && run_done && (cnt == W'(RECOV_RUNS - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (busoff) begin
         if (recov_hit)     cnt <= '0;
         else if (run_done) cnt <= cnt + 1'b1;
      end else if (enter_off) begin
         cnt <= '0;
      end else if (sw_ld) begin
         cnt <= sw_val;
      end else begin
         cnt <= next_w;
      end
   end
endmodule

// File: rtl/can_fault_conf.sv
`timescale 1ns/1ps
module can_fault_conf #(
   parameter int unsigned TEC_W      = 9,
   parameter int unsigned REC_W      = 8,
   parameter int unsigned PASS_LIM   = 128,
   parameter int unsigned OFF_LIM    = 256,
   parameter int unsigned RELOAD     = 119,
   parameter int unsigned RUN_LEN    = 11,
   parameter int unsigned RECOV_RUNS = 128,
   parameter bit          REC_LVL    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mod_clr,
   input  logic             ev_rx_err,
   input  logic             ev_rx_flagerr,
   input  logic             ev_tx_flag,
   input  logic             ev_tx_flagerr,
   input  logic             ev_dom_run,
   input  logic             ev_tx_ok,
   input  logic             ev_rx_ok,
   input  logic             bit_valid,
   input  logic             bus_bit,
   input  logic             sw_wr,
   input  logic [REC_W-1:0] sw_wdata,
   output logic [TEC_W-1:0] tec,
   output logic [REC_W-1:0] rec,
   output logic [1:0]       fc_state,
   output logic             flag_passive,
   output logic             recov_irq
);
   import canfc_pkg::*;

   generate
      if ((2 ** TEC_W) <= (OFF_LIM + 24)) begin : g_chk_tec_w
         $error("TEC_W too narrow for OFF_LIM plus one cycle of increments");
      end
      if ((2 ** REC_W) <= (PASS_LIM + 17)) begin : g_chk_rec_w
         $error("REC_W too narrow for PASS_LIM plus one cycle of increments");
      end
      if (RELOAD >= PASS_LIM) begin : g_chk_reload
         $error("RELOAD must lie below PASS_LIM");
      end
      if (RECOV_RUNS < 1 || RECOV_RUNS >= (2 ** REC_W)) begin : g_chk_runs
         $error("RECOV_RUNS out of range for REC_W");
      end
      if (RUN_LEN < 2) begin : g_chk_run_len
         $error("RUN_LEN must be at least 2");
      end
      if (TEC_W <= REC_W) begin : g_chk_widths
         $error("TEC_W must exceed REC_W");
      end
   endgenerate

   logic       busoff_q;
   logic       irq_q;
   logic       sw_ld;
   logic       off_hit;
   logic       run_done;
   logic       recov_hit;
   logic [1:0] tx_inc8_n;
   logic [1:0] rx_inc8_n;
   fc_state_e  st;

   assign sw_ld     = sw_wr && !busoff_q;
   assign tx_inc8_n = {1'b0, ev_tx_flag} + {1'b0, ev_tx_flagerr} + {1'b0, ev_dom_run};
   assign rx_inc8_n = {1'b0, ev_rx_flagerr} + {1'b0, ev_dom_run};

   canfc_tx_count #(.W(TEC_W), .OFF_LIM(OFF_LIM)) tx_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (mod_clr),
      .hold    (busoff_q),
      .recover (recov_hit),
      .sw_ld   (sw_ld),
      .sw_val  ({{(TEC_W-REC_W){1'b0}}, sw_wdata}),
      .inc8_n  (tx_inc8_n),
      .dec_req (ev_tx_ok),
      .cnt     (tec),
      .off_hit (off_hit)
   );

   canfc_rx_count #(.W(REC_W), .PASS_LIM(PASS_LIM), .RELOAD(RELOAD),
                    .RECOV_RUNS(RECOV_RUNS)) rx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (mod_clr),
      .busoff    (busoff_q),
      .enter_off (off_hit),
      .sw_ld     (sw_ld),
      .sw_val    (sw_wdata),
      .inc1      (ev_rx_err),
      .inc8_n    (rx_inc8_n),
      .good_rx   (ev_rx_ok),
      .run_done  (run_done),
      .cnt       (rec),
      .recov_hit (recov_hit)
   );

   canfc_run_detect #(.RUN_LEN(RUN_LEN), .REC_LVL(REC_LVL)) run_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (mod_clr || !busoff_q),
      .bit_valid (bit_valid),
      .bus_bit   (bus_bit),
      .run_done  (run_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busoff_q <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         irq_q <= !mod_clr && recov_hit;
         if (mod_clr || recov_hit) busoff_q <= 1'b0;
         else if (off_hit)         busoff_q <= 1'b1;
      end
   end

   always_comb begin
      if (busoff_q)                                        st = FC_BUSOFF;
      else if (tec >= TEC_W'(PASS_LIM) || rec >= REC_W'(PASS_LIM)) st = FC_PASSIVE;
      else                                                 st = FC_ACTIVE;
   end

   assign fc_state     = st;
   assign flag_passive = (st == FC_PASSIVE);
   assign recov_irq    = irq_q;
endmodule

// File: rtl/canfc_checker.sv
`timescale 1ns/1ps
module canfc_checker #(
   parameter int unsigned TEC_W    = 9,
   parameter int unsigned REC_W    = 8,
   parameter int unsigned PASS_LIM = 128,
   parameter int unsigned OFF_LIM  = 256
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mod_clr,
   input logic             ev_tx_flag,
   input logic             ev_tx_flagerr,
   input logic             ev_dom_run,
   input logic             ev_tx_ok,
   input logic             ev_rx_ok,
   input logic             sw_wr,
   input logic [REC_W-1:0] sw_wdata,
   input logic [TEC_W-1:0] tec,
   input logic [REC_W-1:0] rec,
   input logic [1:0]       fc_state,
   input logic             recov_irq
);
   a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
      mod_clr |=> (tec == '0 && rec == '0 && fc_state == 2'd0));

   a_r5_tx_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_state != 2'd2 && !mod_clr && !sw_wr && ev_tx_ok && !ev_tx_flag &&
       !ev_tx_flagerr && !ev_dom_run && tec == '0) |=> (tec == '0));

   a_r3_rec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_state != 2'd2 && !mod_clr && !sw_wr && !ev_rx_ok && rec >= REC_W'(PASS_LIM))
      |=> (rec == $past(rec) || fc_state == 2'd2));

   a_r8_busoff_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_state == 2'd2 && !mod_clr)
      |=> (tec == TEC_W'(OFF_LIM) || (recov_irq && tec == '0)));

   a_r9_rec_step: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_state == 2'd2 && !mod_clr)
      |=> (rec == $past(rec) || rec == REC_W'($past(rec) + 1'b1) || recov_irq));

   a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      recov_irq |=> !recov_irq);

   a_r10_irq_state: assert property (@(posedge clk) disable iff (!rst_n)
      recov_irq |-> (fc_state == 2'd0 && tec == '0 && rec == '0));

   a_r11_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && fc_state != 2'd2 && !mod_clr)
      |=> (tec == TEC_W'($past(sw_wdata)) && rec == $past(sw_wdata)));
endmodule

bind can_fault_conf canfc_checker #(
   .TEC_W(TEC_W), .REC_W(REC_W), .PASS_LIM(PASS_LIM), .OFF_LIM(OFF_LIM)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .mod_clr       (mod_clr),
   .ev_tx_flag    (ev_tx_flag),
   .ev_tx_flagerr (ev_tx_flagerr),
   .ev_dom_run    (ev_dom_run),
   .ev_tx_ok      (ev_tx_ok),
   .ev_rx_ok      (ev_rx_ok),
   .sw_wr         (sw_wr),
   .sw_wdata      (sw_wdata),
   .tec           (tec),
   .rec           (rec),
   .fc_state      (fc_state),
   .recov_irq     (recov_irq)
);

// File: tb/can_fault_conf_tb_top.sv
`timescale 1ns/1ps
module can_fault_conf_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mod_clr = 0, ev_rx_err = 0, ev_rx_flagerr = 0, ev_tx_flag = 0;
   logic       ev_tx_flagerr = 0, ev_dom_run = 0, ev_tx_ok = 0, ev_rx_ok = 0;
   logic       bit_valid = 0, bus_bit = 0, sw_wr = 0;
   logic [7:0] sw_wdata = '0;
   logic [8:0] tec;
   logic [7:0] rec;
   logic [1:0] fc_state;
   logic       flag_passive, recov_irq;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   int m_tec = 0, m_rec = 0, m_run = 0;
   bit m_off = 0, m_irq = 0;

   always #4 clk = ~clk;

   can_fault_conf dut_i (
      .clk(clk), .rst_n(rst_n), .mod_clr(mod_clr),
      .ev_rx_err(ev_rx_err), .ev_rx_flagerr(ev_rx_flagerr),
      .ev_tx_flag(ev_tx_flag), .ev_tx_flagerr(ev_tx_flagerr),
      .ev_dom_run(ev_dom_run), .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
      .bit_valid(bit_valid), .bus_bit(bus_bit), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
      .tec(tec), .rec(rec), .fc_state(fc_state), .flag_passive(flag_passive),
      .recov_irq(recov_irq)
   );

   // Reference model built from the requirement text.
   task automatic model_edge();
      int tn, rb, rn;
      m_irq = 0;
      if (mod_clr) begin
         m_tec = 0; m_rec = 0; m_run = 0; m_off = 0;
      end else if (m_off) begin
         if (bit_valid) begin
            if (bus_bit) begin
               m_run++;
               if (m_run == 11) begin
                  m_run = 0;
                  m_rec++;
                  if (m_rec == 128) begin
                     m_tec = 0; m_rec = 0; m_off = 0; m_irq = 1;
                  end
               end
            end else begin
               m_run = 0;
            end
         end
      end else if (sw_wr) begin
         m_tec = int'(sw_wdata); m_rec = int'(sw_wdata);
      end else begin
         tn = m_tec - ((ev_tx_ok && m_tec != 0) ? 1 : 0)
              + 8 * (int'(ev_tx_flag) + int'(ev_tx_flagerr) + int'(ev_dom_run));
         rb = m_rec;
         if (ev_rx_ok) rb = (m_rec == 0) ? 0 : ((m_rec < 128) ? m_rec - 1 : 119);
         rn = (m_rec < 128) ? rb + int'(ev_rx_err) + 8 * (int'(ev_rx_flagerr) + int'(ev_dom_run)) : rb;
         if (tn >= 256) begin
            m_off = 1; m_tec = 256; m_rec = 0; m_run = 0;
         end else begin
            m_tec = tn; m_rec = rn;
         end
      end
   endtask

   task automatic compare(input string req);
      int es;
      es = m_off ? 2 : ((m_tec >= 128 || m_rec >= 128) ? 1 : 0);
      n_chk++;
      if (int'(tec) != m_tec || int'(rec) != m_rec || int'(fc_state) != es ||
          flag_passive != (es == 1) || recov_irq != m_irq) begin
         n_err++;
         $display("FAIL %s: tec=%0d rec=%0d st=%0d fp=%0b irq=%0b expected tec=%0d rec=%0d st=%0d fp=%0b irq=%0b",
                  req, tec, rec, fc_state, flag_passive, recov_irq,
                  m_tec, m_rec, es, (es == 1), m_irq);
      end
   endtask

   task automatic check_eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_in();
      mod_clr = 0; ev_rx_err = 0; ev_rx_flagerr = 0; ev_tx_flag = 0;
      ev_tx_flagerr = 0; ev_dom_run = 0; ev_tx_ok = 0; ev_rx_ok = 0;
      bit_valid = 0; bus_bit = 0; sw_wr = 0;
   endtask

   // Inputs are set at the negedge; one edge; compare at the next negedge.
   task automatic cyc(input string req);
      model_edge();
      @(posedge clk);
      @(negedge clk);
      compare(req);
      clear_in();
   endtask

   task automatic bits(input int n, input bit lvl, input string req);
      for (int i = 0; i < n; i++) begin
         bit_valid = 1; bus_bit = lvl;
         cyc(req);
      end
   endtask

   initial begin
      #(8 * 150000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      clear_in();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      compare("R1 reset");

      // R3/R2: receive +1 sweep through the passive limit and beyond
      for (int i = 0; i < 131; i++) begin ev_rx_err = 1; cyc("R3 rx_err sweep"); end
      check_eq("R3 rec frozen at 128", int'(rec), 128);
      check_eq("R2 passive by rec", int'(fc_state), 1);
      // R6: reload then decrement to floor
      ev_rx_ok = 1; cyc("R6 reload");
      check_eq("R6 reload 119", int'(rec), 119);
      check_eq("R2 back to active", int'(fc_state), 0);
      for (int i = 0; i < 121; i++) begin ev_rx_ok = 1; cyc("R6 decrement"); end
      check_eq("R6 floor at 0", int'(rec), 0);
      ev_rx_flagerr = 1; cyc("R3 rx +8");
      ev_rx_flagerr = 1; cyc("R3 rx +8");
      check_eq("R3 rec 16", int'(rec), 16);

      // R4/R5: transmit increments and saturating decrement
      ev_tx_flag = 1; cyc("R4 tx flag");
      ev_tx_flag = 1; ev_tx_flagerr = 1; cyc("R4 tx two sources");
      check_eq("R4 tec 24", int'(tec), 24);
      for (int i = 0; i < 30; i++) begin ev_tx_ok = 1; cyc("R5 tx_ok"); end
      check_eq("R5 tec floor", int'(tec), 0);
      for (int i = 0; i < 16; i++) begin ev_dom_run = 1; cyc("R4 dom run both"); end
      check_eq("R4 tec 128", int'(tec), 128);
      check_eq("R2 flag passive", int'(flag_passive), 1);

      // R7: combined events in one cycle
      ev_rx_ok = 1; ev_rx_err = 1; ev_tx_ok = 1; ev_tx_flag = 1; cyc("R7 combined");
      check_eq("R7 tec 135", int'(tec), 135);
      check_eq("R7 rec 119", int'(rec), 119);
      ev_rx_ok = 1; ev_rx_flagerr = 1; ev_tx_ok = 1; cyc("R7 dec plus inc");
      check_eq("R7 rec 126", int'(rec), 126);

      // R11: software load beats events
      sw_wr = 1; sw_wdata = 8'd77; ev_tx_flag = 1; ev_rx_err = 1; cyc("R11 sw load");
      check_eq("R11 tec 77", int'(tec), 77);
      check_eq("R11 rec 77", int'(rec), 77);
      sw_wr = 1; sw_wdata = 8'd200; cyc("R11 sw load 200");

      // R8: bus-off entry
      for (int i = 0; i < 7; i++) begin ev_tx_flag = 1; cyc("R8 approach"); end
      check_eq("R8 state bus-off", int'(fc_state), 2);
      check_eq("R8 tec 256", int'(tec), 256);
      ev_rx_err = 1; ev_rx_flagerr = 1; ev_tx_flag = 1; ev_tx_flagerr = 1;
      ev_dom_run = 1; ev_tx_ok = 1; ev_rx_ok = 1; sw_wr = 1; sw_wdata = 8'd5;
      cyc("R8 events ignored");
      check_eq("R8 rec still 0", int'(rec), 0);
      check_eq("R8 tec still 256", int'(tec), 256);

      // R9: run restart and gaps
      bits(10, 1, "R9 partial run");
      bits(1, 0, "R9 dominant restart");
      check_eq("R9 no count", int'(rec), 0);
      bits(5, 1, "R9 run part a");
      for (int i = 0; i < 3; i++) cyc("R9 invalid gap");
      bits(6, 1, "R9 run part b");
      check_eq("R9 one run", int'(rec), 1);
      for (int r = 0; r < 126; r++) bits(11, 1, "R9 runs");
      check_eq("R9 rec 127", int'(rec), 127);
      bits(11, 1, "R10 final run");
      check_eq("R10 irq", int'(recov_irq), 1);
      check_eq("R10 active", int'(fc_state), 0);
      cyc("R10 irq one cycle");
      check_eq("R10 irq low", int'(recov_irq), 0);

      // R1: module clear, also from bus-off
      sw_wr = 1; sw_wdata = 8'd250; cyc("R11 load");
      mod_clr = 1; ev_tx_flag = 1; cyc("R1 clear");
      sw_wr = 1; sw_wdata = 8'd255; cyc("R11 load 255");
      ev_tx_flag = 1; cyc("R8 enter");
      check_eq("R8 bus-off again", int'(fc_state), 2);
      mod_clr = 1; bit_valid = 1; bus_bit = 1; cyc("R1 clear from bus-off");
      check_eq("R1 state active", int'(fc_state), 0);

      // Broad sweep of mixed traffic against the model
      for (int i = 0; i < 6000; i++) begin
         ev_rx_err     = ($urandom_range(0, 3) == 0);
         ev_rx_flagerr = ($urandom_range(0, 15) == 0);
         ev_tx_flag    = ($urandom_range(0, 11) == 0);
         ev_tx_flagerr = ($urandom_range(0, 31) == 0);
         ev_dom_run    = ($urandom_range(0, 31) == 0);
         ev_tx_ok      = ($urandom_range(0, 2) == 0);
         ev_rx_ok      = ($urandom_range(0, 2) == 0);
         sw_wr         = ($urandom_range(0, 63) == 0);
         sw_wdata      = 8'($urandom_range(0, 255));
         mod_clr       = ($urandom_range(0, 1023) == 0);
         bit_valid     = ($urandom_range(0, 3) != 0);
         bus_bit       = ($urandom_range(0, 31) != 0);
         cyc("R7 mixed sweep");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule